// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the multi-cycle control that saves and restores processor context around an interrupt. It owns the program counter, the processor status word, and two shadow stack pointers: one for the supervisor stack and one for the user stack. It does not hold the stack pointer register itself. The datapath presents that register on `r6_in`, and the block writes it back once at the end of each sequence. The block reads and writes memory through a request channel with a valid/ready handshake and a read-response strobe. Instruction decode and the ALU sit outside the block.

The block acts only while idle and only when `fetch_start` marks the first state of an instruction cycle. At that point a pending interrupt starts the entry sequence. On entry the block moves onto the supervisor stack if the interrupted program ran in user mode. It pushes the status word and then the PC, and fetches the handler address from the vector table page. It then loads that handler address into the PC and rewrites the status word to supervisor mode with the request's level and cleared condition codes. If no interrupt is pending, a return request starts the return sequence. That sequence pops the PC and then the status word. If the restored mode is user, it swaps back to the user stack. Each sequence ends with a one-cycle `done` pulse and the stack pointer write-back, and the block then goes back to waiting for the next fetch.

Back-pressure rules for the memory channel are as follows. A request is transferred in a cycle where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, the block holds `mem_addr`, `mem_we` and `mem_wdata` unchanged. Read data is taken in the first cycle with `mem_rvalid` high after the read was transferred, and the wait may last any number of cycles. The response side has no ready, so the block always accepts the data.

Top module: `irq_ctx_seq`

## Requirements
- R1: `fetch_start` is sampled only while `busy` is low. A high `int_req` or `ret_req` without `fetch_start`, or any `fetch_start` while `busy` is high, causes no memory request and no register change.
- R2: The status word uses bit 15 for privilege (1 = user, 0 = supervisor), bits 10:8 for the priority level and bits 2:0 for the condition codes. The reset values are status 0x8002, PC 0x0400, supervisor stack pointer 0x3000 and user stack pointer 0x0000.
- R3: On entry from user mode, `r6_in` is saved as the user stack pointer and the pushes use the supervisor stack pointer. On entry from supervisor mode, the pushes use `r6_in` and no swap takes place.
- R4: Each push pre-decrements the stack pointer. The status word is written at SP-1 and then the PC at SP-2, and R6 is written with SP-2 at the end of the sequence.
- R5: The handler address is read from address {0x01, vector}, and the PC is loaded with the word returned by that read.
- R6: After entry, the status word has bit 15 = 0, bits 10:8 = `int_lvl` and bits 2:0 = 0. Bits 14:11 and 7:3 keep their earlier values.
- R7: A return reads the PC at R6 and the status word at R6+1, with each pop post-incrementing. If the restored mode is supervisor, R6 is written with R6+2.
- R8: If the restored status word has bit 15 = 1, R6+2 is stored as the supervisor stack pointer and R6 is written with the saved user stack pointer.
- R9: When `int_req` and `ret_req` are both high at a sampled `fetch_start`, the entry sequence runs and the return request is dropped.
- R10: A memory request is held stable while `mem_ready` is low. Stalls on the request or the response do not change the values written, read or loaded.
- R11: `done` is high for exactly one cycle at the end of each sequence. `r6_we` is high only in that cycle, and `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| fetch_start | input | 1 | First state of an instruction cycle |
| int_req | input | 1 | Interrupt request already qualified by priority |
| int_vec | input | 8 | Vector of the winning request |
| int_lvl | input | 3 | Priority level of the winning request |
| ret_req | input | 1 | Return-from-interrupt requested by decode |
| r6_in | input | 16 | Current stack pointer register value |
| r6_we | output | 1 | Stack pointer write enable |
| r6_wdata | output | 16 | Stack pointer write value |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 16 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| pc_o | output | 16 | Program counter |
| psr_o | output | 16 | Processor status word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong shadow stack pointer stays hidden until the next privilege change. A bad supervisor pointer shows up as misplaced push addresses on the next entry from user mode. A bad user pointer shows up as a wrong `r6_wdata` on the next return to user mode, which may come several sequences later. For this reason the bench chains entries and returns across both modes and checks every memory address as well as the final register values. A wrong sequencing state shows within one transfer, as a write in place of a read, a swapped push order or a request that changes under stall. A wrong status rewrite shows on `psr_o` in the cycle `done` rises.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

  localparam int WORD_W    = 16;
  localparam int SR_PRIV   = 15;
  localparam int SR_LVL_LO = 8;
  localparam int SR_LVL_W  = 3;
  localparam int SR_CC_W   = 3;

  localparam int SLOT_PC  = 0;
  localparam int SLOT_SR  = 1;
  localparam int SLOT_SSP = 2;
  localparam int SLOT_USP = 3;
  localparam int N_SLOTS  = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_SR,
    ST_PUSH_PC,
    ST_VEC_REQ,
    ST_VEC_WAIT,
    ST_POP_PC_REQ,
    ST_POP_PC_WAIT,
    ST_POP_SR_REQ,
    ST_POP_SR_WAIT,
    ST_DONE
  } seq_state_e;

  // Status word for the handler: supervisor, new level, flags cleared.
  function automatic word_t sr_on_entry(word_t sr, logic [SR_LVL_W-1:0] lvl);
    word_t r;
    r = sr;
    r[SR_PRIV] = 1'b0;
    r[SR_LVL_LO +: SR_LVL_W] = lvl;
    r[SR_CC_W-1:0] = '0;
    return r;
  endfunction

endpackage

// File: rtl/irqseq_ctx_regs.sv
module irqseq_ctx_regs
  import irqseq_pkg::*;
#(
  parameter word_t PC_RST  = 16'h0400,
  parameter word_t SR_RST  = 16'h8002,
  parameter word_t SSP_RST = 16'h3000,
  parameter word_t USP_RST = 16'h0000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_SLOTS-1:0]             ld,
  input  logic [N_SLOTS-1:0][WORD_W-1:0] d,
  output logic [N_SLOTS-1:0][WORD_W-1:0] q
);

  localparam logic [N_SLOTS-1:0][WORD_W-1:0] RST_VALS =
    {USP_RST, SSP_RST, SR_RST, PC_RST};

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)     q[g] <= RST_VALS[g];
      else if (ld[g]) q[g] <= d[g];
    end
  end

endmodule

// File: rtl/irqseq_fsm.sv
module irqseq_fsm
  import irqseq_pkg::*;
#(
  parameter int                        VEC_W      = 8,
  parameter logic [WORD_W-VEC_W-1:0]   TABLE_PAGE = 'h01
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fetch_start,
  input  logic                           int_req,
  input  logic [VEC_W-1:0]               int_vec,
  input  logic [SR_LVL_W-1:0]            int_lvl,
  input  logic                           ret_req,
  input  word_t                          r6_in,
  input  logic [N_SLOTS-1:0][WORD_W-1:0] ctx_q,
  output logic [N_SLOTS-1:0]             ctx_ld,
  output logic [N_SLOTS-1:0][WORD_W-1:0] ctx_d,
  output logic                           mem_valid,
  input  logic                           mem_ready,
  output logic                           mem_we,
  output word_t                          mem_addr,
  output word_t                          mem_wdata,
  input  logic                           mem_rvalid,
  input  word_t                          mem_rdata,
  output logic                           r6_we,
  output word_t                          r6_wdata,
  output logic                           busy,
  output logic                           done
);

  seq_state_e            state_q, state_d;
  word_t                 sp_q, sp_d;
  word_t                 r6_fin_q, r6_fin_d;
  logic [VEC_W-1:0]      vec_q, vec_d;
  logic [SR_LVL_W-1:0]   lvl_q, lvl_d;

  word_t pc_cur, sr_cur, ssp_cur, usp_cur;
  assign pc_cur  = ctx_q[SLOT_PC];
  assign sr_cur  = ctx_q[SLOT_SR];
  assign ssp_cur = ctx_q[SLOT_SSP];
  assign usp_cur = ctx_q[SLOT_USP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sp_q     <= '0;
      r6_fin_q <= '0;
      vec_q    <= '0;
      lvl_q    <= '0;
    end else begin
      state_q  <= state_d;
      sp_q     <= sp_d;
      r6_fin_q <= r6_fin_d;
      vec_q    <= vec_d;
      lvl_q    <= lvl_d;
    end
  end

  always_comb begin
    state_d   = state_q;
    sp_d      = sp_q;
    r6_fin_d  = r6_fin_q;
    vec_d     = vec_q;
    lvl_d     = lvl_q;
    ctx_ld    = '0;
    ctx_d     = ctx_q;
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp_q;
    mem_wdata = '0;
    r6_we     = 1'b0;
    r6_wdata  = r6_fin_q;
    done      = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (fetch_start && int_req) begin
          vec_d = int_vec;
          lvl_d = int_lvl;
          if (sr_cur[SR_PRIV]) begin
            ctx_ld[SLOT_USP] = 1'b1;
            ctx_d[SLOT_USP]  = r6_in;
            sp_d             = ssp_cur - 1'b1;
          end else begin
            sp_d = r6_in - 1'b1;
          end
          state_d = ST_PUSH_SR;
        end else if (fetch_start && ret_req) begin
          sp_d    = r6_in;
          state_d = ST_POP_PC_REQ;
        end
      end

      ST_PUSH_SR: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = sr_cur;
        if (mem_ready) begin
          sp_d    = sp_q - 1'b1;
          state_d = ST_PUSH_PC;
        end
      end

      ST_PUSH_PC: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = pc_cur;
        if (mem_ready) state_d = ST_VEC_REQ;
      end

      ST_VEC_REQ: begin
        mem_valid = 1'b1;
        mem_addr  = {TABLE_PAGE, vec_q};
        if (mem_ready) state_d = ST_VEC_WAIT;
      end

      ST_VEC_WAIT: begin
        if (mem_rvalid) begin
          ctx_ld[SLOT_PC] = 1'b1;
          ctx_d[SLOT_PC]  = mem_rdata;
          ctx_ld[SLOT_SR] = 1'b1;
          ctx_d[SLOT_SR]  = sr_on_entry(sr_cur, lvl_q);
          r6_fin_d        = sp_q;
          state_d         = ST_DONE;
        end
      end

      ST_POP_PC_REQ: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          sp_d    = sp_q + 1'b1;
          state_d = ST_POP_PC_WAIT;
        end
      end

      ST_POP_PC_WAIT: begin
        if (mem_rvalid) begin
          ctx_ld[SLOT_PC] = 1'b1;
          ctx_d[SLOT_PC]  = mem_rdata;
          state_d         = ST_POP_SR_REQ;
        end
      end

      ST_POP_SR_REQ: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          sp_d    = sp_q + 1'b1;
          state_d = ST_POP_SR_WAIT;
        end
      end

      ST_POP_SR_WAIT: begin
        if (mem_rvalid) begin
          ctx_ld[SLOT_SR] = 1'b1;
          ctx_d[SLOT_SR]  = mem_rdata;
          if (mem_rdata[SR_PRIV]) begin
            ctx_ld[SLOT_SSP] = 1'b1;
            ctx_d[SLOT_SSP]  = sp_q;
            r6_fin_d         = usp_cur;
          end else begin
            r6_fin_d = sp_q;
          end
          state_d = ST_DONE;
        end
      end

      ST_DONE: begin
        r6_we   = 1'b1;
        done    = 1'b1;
        state_d = ST_IDLE;
      end

      default: state_d = ST_IDLE;
    endcase
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irqseq_pkg::*;
#(
  parameter int                      VEC_W      = 8,
  parameter logic [WORD_W-VEC_W-1:0] TABLE_PAGE = 'h01,
  parameter word_t                   PC_RST     = 16'h0400,
  parameter word_t                   SR_RST     = 16'h8002,
  parameter word_t                   SSP_RST    = 16'h3000,
  parameter word_t                   USP_RST    = 16'h0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_start,
  input  logic                int_req,
  input  logic [VEC_W-1:0]    int_vec,
  input  logic [SR_LVL_W-1:0] int_lvl,
  input  logic                ret_req,
  input  logic [WORD_W-1:0]   r6_in,
  output logic                r6_we,
  output logic [WORD_W-1:0]   r6_wdata,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [WORD_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic                mem_rvalid,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic [WORD_W-1:0]   pc_o,
  output logic [WORD_W-1:0]   psr_o,
  output logic                busy,
  output logic                done
);

  logic [N_SLOTS-1:0]             ctx_ld;
  logic [N_SLOTS-1:0][WORD_W-1:0] ctx_d;
  logic [N_SLOTS-1:0][WORD_W-1:0] ctx_q;

  irqseq_ctx_regs #(
    .PC_RST (PC_RST),
    .SR_RST (SR_RST),
    .SSP_RST(SSP_RST),
    .USP_RST(USP_RST)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .ld   (ctx_ld),
    .d    (ctx_d),
    .q    (ctx_q)
  );

  irqseq_fsm #(
    .VEC_W     (VEC_W),
    .TABLE_PAGE(TABLE_PAGE)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_start(fetch_start),
    .int_req    (int_req),
    .int_vec    (int_vec),
    .int_lvl    (int_lvl),
    .ret_req    (ret_req),
    .r6_in      (r6_in),
    .ctx_q      (ctx_q),
    .ctx_ld     (ctx_ld),
    .ctx_d      (ctx_d),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .r6_we      (r6_we),
    .r6_wdata   (r6_wdata),
    .busy       (busy),
    .done       (done)
  );

  assign pc_o  = ctx_q[SLOT_PC];
  assign psr_o = ctx_q[SLOT_SR];

endmodule

// File: rtl/irqseq_chk.sv
module irqseq_chk
  import irqseq_pkg::*;
#(
  parameter int                      VEC_W      = 8,
  parameter logic [WORD_W-VEC_W-1:0] TABLE_PAGE = 'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_start,
  input logic              int_req,
  input logic              r6_we,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [WORD_W-1:0] psr_o,
  input logic              busy,
  input logic              done
);

  logic        in_entry;
  logic [1:0]  wr_cnt;
  word_t       sr_cap;
  word_t       first_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_entry   <= 1'b0;
      wr_cnt     <= '0;
      sr_cap     <= '0;
      first_addr <= '0;
    end else begin
      if (!busy && fetch_start && int_req) begin
        in_entry <= 1'b1;
        wr_cnt   <= '0;
        sr_cap   <= psr_o;
      end else if (done) begin
        in_entry <= 1'b0;
      end
      if (in_entry && mem_valid && mem_we && mem_ready) begin
        wr_cnt <= wr_cnt + 1'b1;
        if (wr_cnt == 2'd0) first_addr <= mem_addr;
      end
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata));

  p_r6_only_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    r6_we |-> done);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  p_entry_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && in_entry |-> !psr_o[SR_PRIV] && psr_o[SR_CC_W-1:0] == '0);

  p_first_push_sr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_entry && mem_valid && mem_we && wr_cnt == 2'd0 |-> mem_wdata == sr_cap);

  p_second_push_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_entry && mem_valid && mem_we && wr_cnt == 2'd1 |->
      mem_addr == first_addr - 1'b1);

  p_vec_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_entry && mem_valid && !mem_we |-> mem_addr[WORD_W-1:VEC_W] == TABLE_PAGE);

endmodule

bind irq_ctx_seq irqseq_chk #(
  .VEC_W     (VEC_W),
  .TABLE_PAGE(TABLE_PAGE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_start(fetch_start),
  .int_req    (int_req),
  .r6_we      (r6_we),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .psr_o      (psr_o),
  .busy       (busy),
  .done       (done)
);

// File: tb/tb_irq_ctx_seq.sv
`timescale 1ns/1ps
module tb_irq_ctx_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_start = 1'b0;
  logic        int_req = 1'b0;
  logic [7:0]  int_vec = '0;
  logic [2:0]  int_lvl = '0;
  logic        ret_req = 1'b0;
  logic [15:0] r6 = '0;
  logic        r6_we;
  logic [15:0] r6_wdata;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b1;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] pc_o, psr_o;
  logic        busy, done;

  // bench-side controls, consumed by the memory/R6 model
  logic        stall_en = 1'b0;
  logic        poke_en = 1'b0;
  logic [15:0] poke_addr = '0, poke_data = '0;
  logic        r6_force = 1'b0;
  logic [15:0] r6_force_val = '0;

  logic [15:0] mem [0:4095];
  logic [15:0] wr_a [0:63];
  logic [15:0] wr_d [0:63];
  logic [15:0] rd_a [0:63];
  int          wr_n = 0, rd_n = 0;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_ctx_seq dut (
    .clk(clk), .rst_n(rst_n), .fetch_start(fetch_start), .int_req(int_req),
    .int_vec(int_vec), .int_lvl(int_lvl), .ret_req(ret_req), .r6_in(r6),
    .r6_we(r6_we), .r6_wdata(r6_wdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pc_o(pc_o), .psr_o(psr_o), .busy(busy), .done(done)
  );

  // memory, R6 and handshake model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[256+i] <= 16'h1000 + 16'(i << 4);
      mem_rvalid <= 1'b0;
      mem_ready  <= 1'b1;
    end else begin
      mem_ready  <= stall_en ? ~mem_ready : 1'b1;
      mem_rvalid <= 1'b0;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          mem[mem_addr[11:0]] <= mem_wdata;
          wr_a[wr_n[5:0]] <= mem_addr;
          wr_d[wr_n[5:0]] <= mem_wdata;
          wr_n <= wr_n + 1;
        end else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[mem_addr[11:0]];
          rd_a[rd_n[5:0]] <= mem_addr;
          rd_n <= rd_n + 1;
        end
      end
      if (poke_en) mem[poke_addr[11:0]] <= poke_data;
    end
    if (r6_we) r6 <= r6_wdata;
    else if (r6_force) r6 <= r6_force_val;
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_r6(logic [15:0] v);
    @(negedge clk); r6_force = 1'b1; r6_force_val = v;
    @(negedge clk); r6_force = 1'b0;
  endtask

  task automatic poke(logic [15:0] a, logic [15:0] d);
    @(negedge clk); poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk); poke_en = 1'b0;
  endtask

  // waits for done, checks it is a single pulse, leaves time for R6 update
  task automatic wait_done(string req);
    int t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    chk({req, " done seen"}, 16'(done), 16'h1);
    @(negedge clk);
    chk({req, " done one cycle"}, 16'(done), 16'h0);
    chk({req, " idle after done"}, 16'(busy), 16'h0);
  endtask

  task automatic launch(logic irq, logic ret, logic [7:0] v, logic [2:0] l, int hold);
    @(negedge clk);
    int_req = irq; ret_req = ret; int_vec = v; int_lvl = l; fetch_start = 1'b1;
    for (int i = 1; i < hold; i++) @(negedge clk);
    @(negedge clk);
    fetch_start = 1'b0; int_req = 1'b0; ret_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 reset status", psr_o, 16'h8002);
    chk("R2 reset pc", pc_o, 16'h0400);
    chk("R11 reset busy", 16'(busy), 16'h0);
    chk("R11 reset done", 16'(done), 16'h0);
  endtask

  task automatic t_ignore;
    int w0 = wr_n, r0 = rd_n;
    @(negedge clk); int_req = 1'b1; ret_req = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk("R1 no fetch no busy", 16'(busy), 16'h0);
    end
    int_req = 1'b0; ret_req = 1'b0;
    chk("R1 no writes", 16'(wr_n - w0), 16'h0);
    chk("R1 no reads", 16'(rd_n - r0), 16'h0);
    chk("R1 pc kept", pc_o, 16'h0400);
  endtask

  // user -> supervisor with stalls; fetch_start held while busy (R11, R10)
  task automatic t_entry_user;
    int w0 = wr_n, r0 = rd_n;
    set_r6(16'hFE00);
    stall_en = 1'b1;
    launch(1'b1, 1'b0, 8'h80, 3'd4, 3);
    wait_done("R3");
    stall_en = 1'b0;
    chk("R11 one entry writes", 16'(wr_n - w0), 16'h2);
    chk("R11 one entry reads", 16'(rd_n - r0), 16'h1);
    chk("R4 push sr addr", wr_a[w0[5:0]], 16'h2FFF);
    chk("R4 push sr data", wr_d[w0[5:0]], 16'h8002);
    chk("R4 push pc addr", wr_a[w0[5:0]+1], 16'h2FFE);
    chk("R10 push pc data", wr_d[w0[5:0]+1], 16'h0400);
    chk("R5 vector addr", rd_a[r0[5:0]], 16'h0180);
    chk("R5 handler pc", pc_o, 16'h1800);
    chk("R6 entry status", psr_o, 16'h0400);
    chk("R3 r6 on ssp", r6, 16'h2FFE);
  endtask

  task automatic t_entry_nested;
    int w0 = wr_n, r0 = rd_n;
    launch(1'b1, 1'b0, 8'h02, 3'd6, 1);
    wait_done("R3 nested");
    chk("R3 no swap addr", wr_a[w0[5:0]], 16'h2FFD);
    chk("R4 nested sr", wr_d[w0[5:0]], 16'h0400);
    chk("R4 nested pc addr", wr_a[w0[5:0]+1], 16'h2FFC);
    chk("R4 nested pc", wr_d[w0[5:0]+1], 16'h1800);
    chk("R5 nested vec", rd_a[r0[5:0]], 16'h0102);
    chk("R5 nested pc", pc_o, 16'h1020);
    chk("R6 nested status", psr_o, 16'h0600);
    chk("R4 nested r6", r6, 16'h2FFC);
  endtask

  task automatic t_ret_super;
    int w0 = wr_n, r0 = rd_n;
    stall_en = 1'b1;
    launch(1'b0, 1'b1, 8'h00, 3'd0, 1);
    wait_done("R7");
    stall_en = 1'b0;
    chk("R7 no writes", 16'(wr_n - w0), 16'h0);
    chk("R7 pop pc addr", rd_a[r0[5:0]], 16'h2FFC);
    chk("R7 pop sr addr", rd_a[r0[5:0]+1], 16'h2FFD);
    chk("R7 pc", pc_o, 16'h1800);
    chk("R7 status", psr_o, 16'h0400);
    chk("R7 r6", r6, 16'h2FFE);
  endtask

  task automatic t_ret_user;
    launch(1'b0, 1'b1, 8'h00, 3'd0, 1);
    wait_done("R8");
    chk("R8 pc", pc_o, 16'h0400);
    chk("R8 status", psr_o, 16'h8002);
    chk("R8 r6 from usp", r6, 16'hFE00);
  endtask

  // SSP moved by a crafted return, then seen on the next user entry
  task automatic t_ssp_moves;
    int w0, r0;
    set_r6(16'hF000);
    launch(1'b1, 1'b0, 8'h10, 3'd1, 1);
    wait_done("R3 second");
    chk("R5 vec 10", pc_o, 16'h1100);
    chk("R6 level 1", psr_o, 16'h0100);
    poke(16'h2F00, 16'h0555);
    poke(16'h2F01, 16'hF8F9);
    set_r6(16'h2F00);
    launch(1'b0, 1'b1, 8'h00, 3'd0, 1);
    wait_done("R8 crafted");
    chk("R8 crafted pc", pc_o, 16'h0555);
    chk("R2 crafted status", psr_o, 16'hF8F9);
    chk("R8 usp restored", r6, 16'hF000);
    w0 = wr_n; r0 = rd_n;
    set_r6(16'hE000);
    launch(1'b1, 1'b1, 8'hFF, 3'd5, 1);
    wait_done("R9");
    chk("R9 entry wins writes", 16'(wr_n - w0), 16'h2);
    chk("R8 new ssp push addr", wr_a[w0[5:0]], 16'h2F01);
    chk("R4 pushed status", wr_d[w0[5:0]], 16'hF8F9);
    chk("R4 pushed pc", wr_d[w0[5:0]+1], 16'h0555);
    chk("R5 vec ff addr", rd_a[r0[5:0]], 16'h01FF);
    chk("R5 vec ff pc", pc_o, 16'h1FF0);
    chk("R6 kept fields", psr_o, 16'h7DF8);
    chk("R9 r6", r6, 16'h2F00);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignore();
    t_entry_user();
    t_entry_nested();
    t_ret_super();
    t_ret_user();
    t_ssp_moves();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule